// File: doc/BRIEF.md
# Cascadable Framed Serial Sample Output Port

This block is the transmit side of a multi-channel sampling device's serial link. A `start` pulse tells it that a new set of channel results is ready. For each enabled channel it then sends one 16-bit word, MSB first, one bit per clock. A one-cycle frame pulse in the clock before the first bit marks the start of each word. Channels whose enable bit is clear are skipped and take no time on the link.

Several identical devices can be chained. Each device's data and frame outputs feed the upstream data and frame inputs of the next device, and the device at the end of the chain drives the host receiver. A device-count field, holding the chain length minus one, sets how many upstream words each device relays after its own word for each channel. The host therefore sees, channel by channel, the nearest device's word first and then the words of the devices further up the chain. The length of a channel slot depends on the device count, and a final flag marks the end of the sequence.

Top module: `cso_port`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sfo`, `sdo` and `done` are 0.
- R2: Each word is a single-cycle `sfo` pulse (slot cycle 0), followed by the 16 bits of the sample on `sdo` in the next 16 cycles, MSB first.
- R3: When `start` is sampled high on a clock edge, the first frame pulse appears in the cycle right after that edge. That cycle is slot cycle 0 of channel 0. A new `start` restarts the sequence.
- R4: Channels are sent in ascending index order. A channel whose `chan_en` bit is 0 gets no slot and no frame pulse. The next enabled channel's frame follows directly.
- R5: Channel 0 is always sent, whatever the value of `chan_en[0]`.
- R6: `dev_count` = D holds the number of chained devices minus 1. Every channel slot lasts 16·(D+1)+1 cycles. The next channel's frame pulse therefore comes 16·(D+1)+1 cycles after the current one.
- R7: For k = 1..D, a relay frame pulse is issued at slot cycle 16k only if `sfi` was high at slot cycle 16(k−1). The bits on `sdo` in slot cycles 16k+1..16k+16 are the `sdi` values of slot cycles 16(k−1)+1..16(k−1)+16, in order.
- R8: With two chained devices both programmed to D=1, the host sees, for each enabled channel in turn: the near device's word (frame at slot cycle 0), then the far device's word (frame at slot cycle 16).
- R9: `done` rises in the cycle after the final cycle of the last enabled channel's slot. It stays high with `sfo` and `sdo` at 0 until the next `start`.
- R10: `dev_count`, `chan_en` and `samples` are captured at `start`. Changing them during a sequence does not change its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | New sample set ready; begins a sequence |
| dev_count | input | DCW (3) | Chain length minus one |
| chan_en | input | NCH (6) | Per-channel enable; bit 0 is forced on |
| samples | input | NCH·WW (96) | Channel results; channel i in bits [16i+15:16i] |
| sdi | input | 1 | Upstream serial data |
| sfi | input | 1 | Upstream frame pulse |
| sdo | output | 1 | Serial data toward the host |
| sfo | output | 1 | Frame pulse toward the host |
| done | output | 1 | Sequence complete |

## Verification
Every result is timed from the edge that samples `start`. The first frame pulse is due one cycle later. After that, frame pulses are due at slot offsets 16k within each slot, and each slot is 16·(D+1)+1 cycles long. Data bits are due 1 to 16 cycles after their frame pulse, and `done` is due in the cycle after the total of all slot lengths. The bench records `sdo`, `sfo` and `done` on every falling edge, with index 0 being the cycle after the start edge. It then checks each expected position against the values the requirements give, and counts frame pulses over the whole window so that an early, late or extra frame pulse is caught.

// File: rtl/cso_pkg.sv
package cso_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SLOT = 1'b1
    } seq_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Slot counter width: enough to reach WW * 2**DCW.
    function automatic int ctr_width(input int ww, input int dcw);
        return $clog2(ww * (1 << dcw) + 1);
    endfunction

endpackage

// File: rtl/cso_chan_pick.sv
module cso_chan_pick #(
    parameter int NCH = 6,
    localparam int CHW = cso_pkg::idx_width(NCH)
) (
    input  logic [NCH-1:0] en,
    input  logic [CHW-1:0] cur,
    output logic [CHW-1:0] nxt,
    output logic           found
);
    logic [NCH-1:0] cand;

    for (genvar i = 0; i < NCH; i++) begin : g_cand
        assign cand[i] = en[i] && (CHW'(i) > cur);
    end

    always_comb begin
        found = 1'b0;
        nxt   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                nxt   = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/cso_shift.sv
module cso_shift #(
    parameter int NCH = 6,
    parameter int WW  = 16,
    localparam int CHW = cso_pkg::idx_width(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NCH*WW-1:0] samples,
    input  logic              load,
    input  logic [CHW-1:0]    sel,
    input  logic              shift,
    input  logic              sdi,
    output logic              bit_out
);
    logic [NCH*WW-1:0] bank_q;
    logic [WW-1:0]     shreg_q;
    logic [WW-1:0]     ld_word;

    always_comb begin
        if (start) ld_word = samples[sel*WW +: WW];
        else       ld_word = bank_q[sel*WW +: WW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= '0;
            shreg_q <= '0;
        end else begin
            if (start) bank_q <= samples;
            if (load)
                shreg_q <= ld_word;
            else if (shift)
                shreg_q <= {shreg_q[WW-2:0], sdi};
        end
    end

    assign bit_out = shreg_q[WW-1];
endmodule

// File: rtl/cso_seq.sv
module cso_seq #(
    parameter int NCH = 6,
    parameter int WW  = 16,
    parameter int DCW = 3,
    localparam int CHW = cso_pkg::idx_width(NCH),
    localparam int CW  = cso_pkg::ctr_width(WW, DCW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [DCW-1:0] dev_count,
    input  logic [NCH-1:0] chan_en,
    input  logic           sfi,
    output logic           load,
    output logic [CHW-1:0] sel,
    output logic           shift,
    output logic           sfo,
    output logic           done,
    output logic           busy
);
    import cso_pkg::*;

    seq_state_e     st_q;
    logic [DCW-1:0] d_q;
    logic [NCH-1:0] en_q;
    logic [CHW-1:0] ch_q;
    logic [CW-1:0]  cnt_q;
    logic           pend_q;
    logic           sfo_q;
    logic           done_q;

    logic [CW-1:0]  last_c;
    logic [CW-1:0]  nxt_c;
    logic           slot_last;
    logic           rel_frame;
    logic           pend_take;
    logic [CHW-1:0] nxt_ch;
    logic           nxt_found;

    cso_chan_pick #(.NCH(NCH)) u_pick (
        .en    (en_q),
        .cur   (ch_q),
        .nxt   (nxt_ch),
        .found (nxt_found)
    );

    always_comb begin
        last_c    = CW'(WW * (int'(d_q) + 1));
        nxt_c     = cnt_q + 1'b1;
        slot_last = (cnt_q == last_c);
        rel_frame = pend_q && ((nxt_c % CW'(WW)) == '0) && (nxt_c < last_c);
        pend_take = ((cnt_q % CW'(WW)) == '0) && (cnt_q < (last_c - CW'(WW)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            d_q    <= '0;
            en_q   <= '0;
            ch_q   <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            sfo_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            st_q   <= SEQ_SLOT;
            d_q    <= dev_count;
            en_q   <= chan_en | NCH'(1);
            ch_q   <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            sfo_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (st_q == SEQ_SLOT) begin
            if (slot_last) begin
                cnt_q  <= '0;
                pend_q <= 1'b0;
                if (nxt_found) begin
                    ch_q  <= nxt_ch;
                    sfo_q <= 1'b1;
                end else begin
                    st_q   <= SEQ_IDLE;
                    sfo_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end else begin
                cnt_q <= nxt_c;
                sfo_q <= rel_frame;
                if (pend_take) pend_q <= sfi;
            end
        end
    end

    assign load  = start || ((st_q == SEQ_SLOT) && slot_last && nxt_found);
    assign sel   = start ? '0 : nxt_ch;
    assign shift = (st_q == SEQ_SLOT) && !slot_last && (cnt_q != '0);
    assign sfo   = sfo_q;
    assign done  = done_q;
    assign busy  = (st_q == SEQ_SLOT);
endmodule

// File: rtl/cso_port.sv
module cso_port #(
    parameter int NCH = 6,
    parameter int WW  = 16,
    parameter int DCW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DCW-1:0]    dev_count,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH*WW-1:0] samples,
    input  logic              sdi,
    input  logic              sfi,
    output logic              sdo,
    output logic              sfo,
    output logic              done
);
    localparam int CHW = cso_pkg::idx_width(NCH);

    logic           load;
    logic [CHW-1:0] sel;
    logic           shift;
    logic           busy;
    logic           bit_out;

    cso_seq #(.NCH(NCH), .WW(WW), .DCW(DCW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dev_count (dev_count),
        .chan_en   (chan_en),
        .sfi       (sfi),
        .load      (load),
        .sel       (sel),
        .shift     (shift),
        .sfo       (sfo),
        .done      (done),
        .busy      (busy)
    );

    cso_shift #(.NCH(NCH), .WW(WW)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .samples (samples),
        .load    (load),
        .sel     (sel),
        .shift   (shift),
        .sdi     (sdi),
        .bit_out (bit_out)
    );

    assign sdo = busy & bit_out;
endmodule

// File: rtl/cso_port_chk.sv
module cso_port_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic sdo,
    input logic sfo,
    input logic done
);
    // R2: a frame pulse lasts exactly one cycle unless a restart reloads it
    p_frame_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (sfo && !start) |=> !sfo);

    // R3: a sampled start produces a frame pulse in the next cycle
    p_start_frame_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> sfo);

    // R9: no frame pulse while the sequence is complete
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !sfo);

    // R9: data line stays low once complete
    p_done_data_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !sdo);

    // R9: completion persists until the next start
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

bind cso_port cso_port_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .sdo   (sdo),
    .sfo   (sfo),
    .done  (done)
);

// File: tb/tb_cso_port.sv
module tb_cso_port;
    localparam int NCH = 6;
    localparam int WW  = 16;
    localparam int DCW = 3;
    localparam int MAXREC = 1024;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [DCW-1:0]    dc_near = '0, dc_far = '0;
    logic [NCH-1:0]    en_near = '0, en_far = '0;
    logic [NCH*WW-1:0] s_near = '0, s_far = '0;
    logic              link_d, link_f, far_done;
    logic              sdo, sfo, done;

    int n_chk = 0;
    int n_fail = 0;

    logic rec_f [MAXREC];
    logic rec_d [MAXREC];
    logic rec_done [MAXREC];

    always #10 clk = ~clk;

    cso_port #(.NCH(NCH), .WW(WW), .DCW(DCW)) u_far (
        .clk(clk), .rst(rst), .start(start), .dev_count(dc_far),
        .chan_en(en_far), .samples(s_far), .sdi(1'b0), .sfi(1'b0),
        .sdo(link_d), .sfo(link_f), .done(far_done)
    );

    cso_port #(.NCH(NCH), .WW(WW), .DCW(DCW)) dut (
        .clk(clk), .rst(rst), .start(start), .dev_count(dc_near),
        .chan_en(en_near), .samples(s_near), .sdi(link_d), .sfi(link_f),
        .sdo(sdo), .sfo(sfo), .done(done)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*WW-1:0] make_pat(input int seed);
        logic [NCH*WW-1:0] v;
        for (int c = 0; c < NCH; c++)
            v[c*WW +: WW] = 16'(seed * 16'h1357 + c * 16'h2469) ^ 16'h8001;
        return v;
    endfunction

    // Pulse start, then record from the cycle after the sampling edge.
    task automatic run_capture(input int n);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < n; i++) begin
            rec_f[i] = sfo;
            rec_d[i] = sdo;
            rec_done[i] = done;
            @(negedge clk);
        end
    endtask

    // Compare a recording with the expected word stream.
    // nw: words with a frame per channel slot; d: programmed count.
    task automatic verify(input string req, input int d, input logic [NCH-1:0] en,
                          input int nw, input logic [NCH*WW-1:0] near_s,
                          input logic [NCH*WW-1:0] far_s, input int n);
        int p = 0;
        int frames = 0;
        int seen = 0;
        int slot = WW * (d + 1) + 1;
        logic [NCH-1:0] m = en | NCH'(1);
        for (int c = 0; c < NCH; c++) begin
            if (m[c]) begin
                for (int k = 0; k < nw; k++) begin
                    logic [WW-1:0] w = '0;
                    logic [WW-1:0] e = (k == 0) ? near_s[c*WW +: WW] : far_s[c*WW +: WW];
                    chk(rec_f[p + WW*k] == 1'b1, {req, " frame position"}, p + WW*k, 1);
                    for (int b = 0; b < WW; b++) w = {w[WW-2:0], rec_d[p + WW*k + 1 + b]};
                    chk(w == e, {req, " word value"}, int'(w), int'(e));
                    frames++;
                end
                p += slot;
            end
        end
        for (int i = 0; i < n; i++) seen += int'(rec_f[i]);
        chk(seen == frames, {req, " frame pulse count"}, seen, frames);
        chk(rec_done[p - 1] == 1'b0 && rec_done[p] == 1'b1, {req, " R9 done timing"},
            int'({rec_done[p-1], rec_done[p]}), 1);
        chk(rec_done[n - 1] == 1'b1 && rec_d[n - 1] == 1'b0, {req, " R9 done hold"},
            int'({rec_done[n-1], rec_d[n-1]}), 2);
    endtask

    task automatic t_reset();
        // R1: idle outputs in and just after reset
        chk(sfo == 1'b0 && sdo == 1'b0 && done == 1'b0, "R1 under reset",
            int'({sfo, sdo, done}), 0);
        @(negedge clk) rst = 1'b0;
        chk(sfo == 1'b0 && sdo == 1'b0 && done == 1'b0, "R1 after release",
            int'({sfo, sdo, done}), 0);
    endtask

    task automatic t_single_all();
        // R2 R3 R4 R6: lone device, every channel
        dc_near = 3'd0; dc_far = 3'd0;
        en_near = '1; en_far = '1;
        s_near = make_pat(3); s_far = make_pat(9);
        run_capture(6 * 17 + 6);
        chk(rec_f[0] == 1'b1, "R3 first frame", int'(rec_f[0]), 1);
        verify("R2 R6 single all", 0, en_near, 1, s_near, s_far, 6 * 17 + 6);
    endtask

    task automatic t_single_sparse();
        // R4 R5: bit 0 cleared yet channel 0 sent; gaps skipped
        dc_near = 3'd0;
        en_near = 6'b101000; en_far = 6'b101000;
        s_near = make_pat(5);
        run_capture(3 * 17 + 4);
        chk(rec_f[17] == 1'b1, "R4 skip to channel 3", int'(rec_f[17]), 1);
        verify("R4 R5 sparse", 0, en_near, 1, s_near, s_far, 3 * 17 + 4);
    endtask

    task automatic t_chain2();
        // R7 R8 R6: two devices, D=1
        dc_near = 3'd1; dc_far = 3'd1;
        en_near = 6'b010011; en_far = 6'b010011;
        s_near = make_pat(11); s_far = make_pat(27);
        run_capture(3 * 33 + 5);
        chk(rec_f[16] == 1'b1 && rec_f[33] == 1'b1, "R8 frame spacing 16 then 17",
            int'({rec_f[16], rec_f[33]}), 3);
        verify("R7 R8 chain of two", 1, en_near, 2, s_near, s_far, 3 * 33 + 5);
    endtask

    task automatic t_chain_d2();
        // R7: D=2 but far device has no upstream frame -> no third frame
        dc_near = 3'd2; dc_far = 3'd2;
        en_near = 6'b000001; en_far = 6'b000001;
        s_near = make_pat(41); s_far = make_pat(42);
        run_capture(49 + 4);
        chk(rec_f[32] == 1'b0, "R7 no relay frame without upstream frame",
            int'(rec_f[32]), 0);
        verify("R6 R7 D=2", 2, en_near, 2, s_near, s_far, 49 + 4);
    endtask

    task automatic t_latch();
        // R10: settings changed mid-sequence have no effect
        logic [NCH*WW-1:0] old_n = make_pat(60);
        logic [NCH*WW-1:0] old_f = make_pat(61);
        dc_near = 3'd1; dc_far = 3'd1;
        en_near = 6'b000110; en_far = 6'b000110;
        s_near = old_n; s_far = old_f;
        fork
            run_capture(3 * 33 + 4);
            begin
                repeat (6) @(negedge clk);
                s_near = make_pat(70); s_far = make_pat(71);
                en_near = '1; en_far = '1;
                dc_near = 3'd0; dc_far = 3'd0;
            end
        join
        verify("R10 captured settings", 1, 6'b000110, 2, old_n, old_f, 3 * 33 + 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        repeat (2) @(negedge clk);
        t_single_all();
        t_single_sparse();
        t_chain2();
        t_chain_d2();
        t_latch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule